// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block connects a clocked host request port to an external byte-wide static RAM that has no clock of its own. The host presents a single read or write, with an address and a byte of write data, on a valid/ready handshake. The block then drives the memory's address lines, its active-low select, read-strobe and write-strobe pins, and the output side of the shared data bus. Each access is built from phases whose lengths are counted in clock cycles.

A write has three parts. First the address and data are set up while the write strobe is still high. Then the strobe is held low for the access-time count. Then address and data stay driven for a hold phase after the strobe returns high. A read asserts the read strobe with the bus undriven by the block. At the end of the access-time count the block captures the returned byte and hands it to the host with a one-cycle valid pulse.

Every access ends with a turnaround phase and an idle cycle. In these cycles every strobe is inactive and nothing drives the bus, so a read can never meet a bus still driven by a previous write. The address width is a parameter: 13 bits for an 8K x 8 part and 15 bits for a 32K x 8 part.

Top module: `async_sram_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, until a request is accepted, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is 1 only when the block is idle. A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1 (`req_write`=1 means write, 0 means read), and `req_ready` is 0 in the following cycle. A request held with `req_valid`=1 while the block is busy is accepted once the block returns to idle.
- R3: Before `mem_we_n` falls, the block spends SETUP_CYC cycles with `mem_cs_n`=0, `mem_we_n`=1, `mem_dq_oe`=1, and the same address and data that it presents during the strobe.
- R4: `mem_we_n` stays 0 for exactly ACCESS_CYC cycles. In the cycle after it rises, `mem_cs_n` is 0, `mem_dq_oe` is 1, and address and data are unchanged from the strobe. This hold phase lasts HOLD_CYC cycles.
- R5: `mem_dq_oe` is 0 in every cycle where `mem_oe_n` is 0, and also in the cycle just before `mem_oe_n` falls. The block never drives the bus while the memory may be driving it.
- R6: A read holds `mem_cs_n`=0 and `mem_oe_n`=0 for ACCESS_CYC cycles. The byte on `mem_dq_in` at the rising edge that ends the last of those cycles is the value returned.
- R7: `rsp_valid` is 1 for exactly one cycle per read, ACCESS_CYC cycles after the first cycle with `mem_oe_n`=0. In that cycle `rsp_rdata` holds the byte stored at the read address (0 for a location never written, with the model memory used by the bench).
- R8: Between two accesses, at least TURN_CYC+1 consecutive cycles have `mem_cs_n`=1, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R9: `mem_cs_n` is 0 for the whole of each access (setup, strobe, hold and read phases) and is 1 whenever `req_ready` is 1.
- R10: `mem_addr` (ADDR_W bits wide) equals the accepted request address throughout the access, including the highest address 2^ADDR_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write byte |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | DATA_W | Captured read byte |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_dq_out | output | DATA_W | Byte the block drives onto the data bus |
| mem_dq_oe | output | 1 | 1 = block drives the data bus |
| mem_dq_in | input | DATA_W | Byte seen on the data bus |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |

## Verification
The bench mixes reads and writes in every order: write followed by read of the same byte, read followed by write, runs of only writes and runs of only reads. Requests are issued while the block is busy, so a design that drops a held request, or accepts one mid-access, loses or misorders scoreboard entries. A model memory stores whatever sits on the bus while the write strobe is low, so a strobe without proper setup or hold lands a wrong byte that a later read exposes. The monitor also measures the strobe width, the read-to-valid latency and the idle gap, and checks that the bus is released before the read strobe falls. A design that shortens a phase, samples read data early or skips the turnaround fails these checks. Addresses 0 and the top address show whether any address bit is dropped.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared phase type for the asynchronous SRAM access sequencer.
// Assumes every phase length parameter is at least one cycle.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WSTROBE = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_READ    = 3'd4,
        PH_TURN    = 3'd5
    } phase_t;

endpackage

// File: rtl/sram_req_latch.sv
// Module: holds the accepted request (address, data, direction) steady for
// the whole access so the memory pins never change mid-access.
// Assumes load is only raised when the sequencer is idle.
module sram_req_latch #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              write_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              write_q
);

    // Capture request fields at acceptance; keep them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            write_q <= 1'b0;
        end else if (load) begin
            addr_q  <= addr_i;
            data_q  <= data_i;
            write_q <= write_i;
        end
    end

    // R10: latched address never moves while no new request is loaded.
    p_addr_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) && $past(rst_n) |-> $stable(addr_q))
        else $error("latched address changed without a load");

endmodule

// File: rtl/sram_phase_seq.sv
// Module: phase sequencer. Walks idle -> setup -> strobe -> hold -> turn for
// writes and idle -> read -> turn for reads, each phase lasting a parameter
// number of cycles, counted down by a shared counter.
// Assumes all phase lengths are at least 1.
module sram_phase_seq
    import sram_ctrl_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int ACCESS_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int TURN_CYC   = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_write,
    output phase_t phase,
    output logic   last
);

    localparam int MAX_A = (SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC;
    localparam int MAX_B = (HOLD_CYC > TURN_CYC) ? HOLD_CYC : TURN_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    logic [CNT_W-1:0] cnt;
    phase_t           nxt;
    logic             advance;

    // Length of a phase minus one, as loaded into the counter.
    function automatic logic [CNT_W-1:0] reload(input phase_t p);
        case (p)
            PH_WSETUP:  reload = CNT_W'(SETUP_CYC - 1);
            PH_WSTROBE: reload = CNT_W'(ACCESS_CYC - 1);
            PH_WHOLD:   reload = CNT_W'(HOLD_CYC - 1);
            PH_READ:    reload = CNT_W'(ACCESS_CYC - 1);
            PH_TURN:    reload = CNT_W'(TURN_CYC - 1);
            default:    reload = '0;
        endcase
    endfunction

    assign last    = (cnt == '0);
    assign advance = (phase == PH_IDLE) ? start : last;

    // Pick the phase that follows the current one.
    always_comb begin
        case (phase)
            PH_IDLE:    nxt = start_write ? PH_WSETUP : PH_READ;
            PH_WSETUP:  nxt = PH_WSTROBE;
            PH_WSTROBE: nxt = PH_WHOLD;
            PH_WHOLD:   nxt = PH_TURN;
            PH_READ:    nxt = PH_TURN;
            default:    nxt = PH_IDLE;
        endcase
    end

    // Phase register and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (advance) begin
            phase <= nxt;
            cnt   <= reload(nxt);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R3: the strobe phase is only ever entered from the setup phase.
    p_strobe_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_WSTROBE && $past(phase) != PH_WSTROBE |-> $past(phase) == PH_WSETUP)
        else $error("write strobe entered without setup");

    // R8: every access passes through the turnaround phase before idle.
    p_turn_before_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_IDLE && $past(phase) != PH_IDLE && $past(rst_n) |-> $past(phase) == PH_TURN)
        else $error("idle reached without turnaround");

endmodule

// File: rtl/sram_rd_capture.sv
// Module: captures the byte on the memory data bus at the end of the read
// access count and raises a one-cycle valid pulse with it.
// Assumes capture is high for exactly one cycle per read.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    // Register read byte and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) rdata <= dq_in;
        end
    end

    // R7: the valid pulse never lasts longer than one cycle.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid)
        else $error("read valid held for more than one cycle");

    // R7: returned byte stays put while no capture happens.
    p_rdata_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(capture) && $past(rst_n) |-> $stable(rdata))
        else $error("read data changed without capture");

endmodule

// File: rtl/async_sram_ctrl.sv
// Module: top of the asynchronous SRAM access sequencer. Takes single host
// requests on a valid/ready port, drives the memory's active-low select and
// strobes from the current phase, and returns read bytes with a valid pulse.
// Assumes the external memory meets its access time within ACCESS_CYC cycles
// and that the pad logic turns mem_dq_out/mem_dq_oe into a tri-state bus.
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int ACCESS_CYC = 3,
    parameter int HOLD_CYC   = 1,
    parameter int TURN_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    phase_t            phase;
    logic              last;
    logic              accept;
    logic              write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign accept = req_valid && req_ready;

    sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .addr_i  (req_addr),
        .data_i  (req_wdata),
        .write_i (req_write),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .write_q (write_q)
    );

    sram_phase_seq #(
        .SETUP_CYC  (SETUP_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .HOLD_CYC   (HOLD_CYC),
        .TURN_CYC   (TURN_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_write (req_write),
        .phase       (phase),
        .last        (last)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (phase == PH_READ && last),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata),
        .rvalid  (rsp_valid)
    );

    // Decode memory pins and host ready from the current phase.
    always_comb begin
        req_ready  = (phase == PH_IDLE);
        mem_cs_n   = (phase == PH_IDLE) || (phase == PH_TURN);
        mem_oe_n   = (phase != PH_READ);
        mem_we_n   = (phase != PH_WSTROBE);
        mem_dq_oe  = (phase == PH_WSETUP) || (phase == PH_WSTROBE) || (phase == PH_WHOLD);
        mem_addr   = addr_q;
        mem_dq_out = data_q;
    end

    // R1: out of reset all strobes are inactive and the bus is released.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready)
        else $error("pins not quiet after reset");

    // R2: a request accepted now leaves the block busy next cycle.
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready)
        else $error("ready still high after acceptance");

    // R3: address and data are driven and steady when the write strobe falls.
    p_write_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(mem_dq_oe) && !$past(mem_cs_n) && $stable(mem_addr) && $stable(mem_dq_out))
        else $error("write strobe fell without setup");

    // R4: after the strobe rises, select and bus drive remain for the hold.
    p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_cs_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out))
        else $error("write hold violated");

    // R5: block never drives the bus while the read strobe is asserted.
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe && mem_we_n)
        else $error("bus contention");

    // R5: bus already released in the cycle before the read strobe falls.
    p_release_before_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe))
        else $error("read strobe right after bus drive");

    // R9: no strobe without select, and select off while idle.
    p_strobe_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !mem_oe_n || mem_dq_oe) |-> !mem_cs_n)
        else $error("strobe or drive without select");

    p_idle_no_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n)
        else $error("select asserted while idle");

endmodule

// File: tb/tb_async_sram_ctrl.sv
// Scoreboard bench: driver tasks issue requests and push expected read bytes
// into a queue, a monitor checks pin timing and pops read results.
module tb_async_sram_ctrl;

    localparam int AW = 13;
    localparam int DW = 8;
    localparam int SETUP = 1;
    localparam int ACC = 3;
    localparam int HOLD = 1;
    localparam int TURN = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out;
    logic          mem_dq_oe;
    logic [DW-1:0] mem_dq_in = '0;
    logic          mem_cs_n, mem_oe_n, mem_we_n;

    int errors = 0;
    int checks = 0;
    bit reported = 0;

    always #5 clk = ~clk;

    async_sram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP),
        .ACCESS_CYC(ACC), .HOLD_CYC(HOLD), .TURN_CYC(TURN)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of the external memory: stores while the write strobe is low.
    logic [DW-1:0] model [int];
    always @(negedge clk) begin
        if (rst_n && !mem_cs_n && !mem_we_n) model[int'(mem_addr)] = mem_dq_out;
        if (!mem_cs_n && !mem_oe_n)
            mem_dq_in <= model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : '0;
        else
            mem_dq_in <= 8'h00;
    end

    // Scoreboard state kept by the driver.
    logic [DW-1:0] exp_mem [int];
    logic [DW-1:0] exp_q [$];
    logic [AW-1:0] addr_q [$];
    int reads_issued = 0;
    int reads_seen = 0;

    // Drive one request and wait until it is taken (R2).
    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (wr) exp_mem[int'(a)] = d;
        else begin
            exp_q.push_back(exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : '0);
            addr_q.push_back(a);
            reads_issued++;
        end
        @(negedge clk);
        chk(!req_ready && !mem_cs_n, "R2/R9 busy with select after accept", {req_ready, mem_cs_n}, 0);
        req_valid = 1'b0;
    endtask

    // Monitor: pin timing and read results, sampled on falling edges.
    int cyc = 0;
    bit prev_we = 1, prev_oe = 1, prev_cs = 1, prev_dq = 0, prev_rv = 0;
    logic [AW-1:0] prev_addr = '0;
    logic [DW-1:0] prev_dout = '0;
    logic [AW-1:0] strobe_addr = '0;
    logic [DW-1:0] strobe_data = '0;
    int we_low = 0;
    int gap = 0;
    bit gap_clean = 1;
    bit seen_access = 0;
    int oe_fall_cyc = 0;
    int setup_run = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!mem_cs_n && mem_we_n && mem_dq_oe && prev_cs == 0 && prev_we && prev_dq)
                setup_run++;
            else if (!mem_cs_n && mem_we_n && mem_dq_oe && prev_cs)
                setup_run = 1;
            if (prev_we && !mem_we_n) begin
                chk(prev_cs == 0 && prev_dq && prev_addr == mem_addr && prev_dout == mem_dq_out
                    && setup_run == SETUP, "R3 setup before write strobe", setup_run, SETUP);
                strobe_addr = mem_addr;
                strobe_data = mem_dq_out;
                we_low = 0;
            end
            if (!mem_we_n) begin
                we_low++;
                if (mem_addr != strobe_addr || mem_dq_out != strobe_data)
                    chk(0, "R4 bus moved during strobe", int'(mem_addr), int'(strobe_addr));
            end
            if (!prev_we && mem_we_n) begin
                chk(we_low == ACC, "R4 strobe width", we_low, ACC);
                chk(!mem_cs_n && mem_dq_oe && mem_addr == strobe_addr && mem_dq_out == strobe_data,
                    "R4 hold after strobe", {mem_cs_n, mem_dq_oe}, 1);
            end
            if (prev_oe && !mem_oe_n) begin
                chk(!prev_dq && !mem_dq_oe, "R5 bus released before read strobe", {prev_dq, mem_dq_oe}, 0);
                oe_fall_cyc = cyc;
                if (addr_q.size() > 0)
                    chk(mem_addr == addr_q[0], "R10 read address on pins", int'(mem_addr), int'(addr_q[0]));
            end
            if (!mem_oe_n && (mem_dq_oe || mem_cs_n))
                chk(0, "R5/R9 drive or no select during read strobe", {mem_dq_oe, mem_cs_n}, 1);
            if (mem_cs_n) begin
                gap++;
                if (!mem_oe_n || !mem_we_n || mem_dq_oe) gap_clean = 0;
            end
            if (prev_cs && !mem_cs_n) begin
                if (seen_access)
                    chk(gap >= TURN + 1 && gap_clean, "R8 idle gap between accesses", gap, TURN + 1);
                seen_access = 1;
                gap = 0;
                gap_clean = 1;
            end
            if (prev_rv) chk(!rsp_valid, "R7 valid is one cycle", rsp_valid, 0);
            if (rsp_valid) begin
                reads_seen++;
                chk(cyc - oe_fall_cyc == ACC, "R6 read latency", cyc - oe_fall_cyc, ACC);
                if (exp_q.size() == 0) chk(0, "R7 unexpected read data", rsp_rdata, 0);
                else begin
                    chk(rsp_rdata == exp_q[0], "R7 read data", rsp_rdata, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(addr_q.pop_front());
                end
            end
            prev_we = mem_we_n; prev_oe = mem_oe_n; prev_cs = mem_cs_n;
            prev_dq = mem_dq_oe; prev_rv = rsp_valid;
            prev_addr = mem_addr; prev_dout = mem_dq_out;
        end
    end

    task automatic finish_run();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        // R1: reset state, held asserted for a few edges with a request present.
        req_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes high in reset", {mem_cs_n, mem_oe_n, mem_we_n}, 7);
        chk(!mem_dq_oe && !rsp_valid, "R1 bus released in reset", {mem_dq_oe, rsp_valid}, 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready && mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 idle after reset",
            {req_ready, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b11110);

        // R6/R7: read of a never-written location returns 0.
        issue(0, 13'h0123, 8'h00);
        // R3/R4/R10: writes at the lowest and highest addresses.
        issue(1, 13'h0000, 8'h5A);
        issue(1, 13'h1FFF, 8'hC3);
        // R8: write then read of the same byte, back to back.
        issue(1, 13'h0AA5, 8'h96);
        issue(0, 13'h0AA5, 8'h00);
        // Read then write, then reread the old and new values.
        issue(0, 13'h1FFF, 8'h00);
        issue(1, 13'h1FFF, 8'h3C);
        issue(0, 13'h1FFF, 8'h00);
        issue(0, 13'h0000, 8'h00);
        // R2: request held high through a busy phase (valid set right away).
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 13'h1555; req_wdata = 8'hE7;
        @(negedge clk);
        chk(!req_ready, "R2 busy while request held", req_ready, 0);
        while (!req_ready) @(negedge clk);
        exp_mem[int'(13'h1555)] = 8'hE7;
        @(negedge clk);
        req_valid = 1'b0;
        issue(0, 13'h1555, 8'h00);
        // Overwrite and a run of reads.
        issue(1, 13'h0000, 8'hFF);
        issue(0, 13'h0000, 8'h00);
        issue(0, 13'h0AA5, 8'h00);
        issue(0, 13'h0123, 8'h00);
        repeat (20) @(negedge clk);
        chk(reads_seen == reads_issued && exp_q.size() == 0, "R7 every read answered",
            reads_seen, reads_issued);
        finish_run();
    end

endmodule